// File: doc/BRIEF.md
# Address-Match Debug Trigger Unit

This block holds a small bank of hardware debug triggers that software programs through three control/status registers. One register chooses a trigger. The other two hold the chosen trigger's control word and its compare address. Every control write passes through a legalizer. The legalizer pins the type code, zeroes the fields this unit does not implement and replaces an unsupported size with the "any size" code. The stored word is therefore always one the matching logic can act on.

At run time the unit watches two request streams. The first is the instruction fetch address. The second is the load/store address, with its width and direction. It compares both against every armed trigger in the same cycle and drives combinational hit outputs, so the pipeline can stop before the access happens. A breakpoint (fetch) hit and a watchpoint (load/store) hit are reported separately, each with the lowest matching trigger index. A trigger arms only when it has at least one privilege-mode bit and at least one access-kind bit. It fires only while the core runs in one of its enabled modes.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset the select register reads 0, every control word reads as type 2 in its top four bits (bits 63:60 for XLEN 64) with all other bits 0, every compare address reads 0, and no hit output is asserted.
- R2: The select register (address 0x7A0) is writable over its full width, reads back the last value written, and never flags an illegal access; when it holds a value of NUM_TRIG or more, accesses to 0x7A1 and 0x7A2 flag illegal, writes to them are dropped and reads return 0.
- R3: Any access to 0x7A3 flags illegal, whichever trigger is selected.
- R4: A control write (0x7A1) stores the type as 2, reads bit 59 as 0, reads bits 20:7 as 0 apart from the size bits 17:16, and keeps bits 0 (load), 1 (store), 2 (execute), 3 (U), 4 (S) and 6 (M) as written.
- R5: The size code is {bits 22:21, bits 17:16}; codes 0, 1, 2, 3 and 5 (any, 1, 2, 4, 8 bytes) are stored as written, and any other code is stored as 0.
- R6: A trigger never fires unless its control word has at least one of U, S or M set and at least one of load, store or execute set.
- R7: With execute set, the breakpoint hit asserts in the same cycle as a valid fetch whose address equals the compare address exactly, and never for any other fetch address.
- R8: With load (or store) set, the watchpoint hit asserts for a valid load (or store) of 2^mem_sz bytes that overlaps the window starting at the compare address, 1/2/4/8 bytes wide by size code, or 8 bytes for code 0; an access of the other direction or one outside the window does not fire.
- R9: A hit also requires the current privilege (0 = U, 1 = S, 3 = M) to have its mode bit set; privilege code 2 never fires.
- R10: When several triggers match in one cycle, the reported index is the lowest one.
- R11: A write to a control word or compare address affects matching from the cycle after the write strobe, not during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_en | input | 1 | Register access strobe, one cycle per access |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, valid in the strobe cycle |
| csr_illegal | output | 1 | Accessed register unavailable |
| priv | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| fetch_vld | input | 1 | Fetch address valid |
| fetch_pc | input | XLEN | Fetch address |
| mem_vld | input | 1 | Load/store request valid |
| mem_store | input | 1 | 1 = store, 0 = load |
| mem_addr | input | XLEN | Load/store byte address |
| mem_sz | input | 2 | Access width as log2 of bytes |
| brk_hit | output | 1 | Fetch trigger hit |
| brk_idx | output | IDX_W | Lowest index of a fetch hit |
| wpt_hit | output | 1 | Load/store trigger hit |
| wpt_idx | output | IDX_W | Lowest index of a load/store hit |

## Verification
The bench aims at window edges. It uses an access that ends one byte short of the window, one that just overlaps its last byte, and one that starts just past it. An off-by-one in the overlap arithmetic would miss or add a hit there. It writes out-of-range size codes (4 and 15) and checks that they read back as 0 and match over 8 bytes. A legalizer that kept them would store garbage and match the wrong width. It checks the half-armed cases (mode bit without access bit and the reverse) and privilege code 2, which a loose enable would let fire. A strobe cycle with a simultaneous fetch would expose a write bypass, and two triggers on one address would expose a priority encoder that favours the highest index.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
   localparam logic [11:0] ADR_SEL  = 12'h7A0;
   localparam logic [11:0] ADR_CTL  = 12'h7A1;
   localparam logic [11:0] ADR_CMP  = 12'h7A2;
   localparam logic [11:0] ADR_AUX  = 12'h7A3;
   localparam logic [3:0]  KIND_AM  = 4'd2;

   // control bit positions the matcher decodes
   localparam int B_LD = 0;
   localparam int B_ST = 1;
   localparam int B_EX = 2;
   localparam int B_U  = 3;
   localparam int B_S  = 4;
   localparam int B_M  = 6;

   typedef enum logic [1:0] {PRV_U = 2'd0, PRV_S = 2'd1, PRV_M = 2'd3} prv_e;

   function automatic logic size_ok(input logic [3:0] code);
      return (code <= 4'd3) || (code == 4'd5);
   endfunction

   // window width in bytes for a stored code; 0 and anything unknown mean 8
   function automatic logic [3:0] size_bytes(input logic [3:0] code);
      case (code)
         4'd1:    return 4'd1;
         4'd2:    return 4'd2;
         4'd3:    return 4'd4;
         default: return 4'd8;
      endcase
   endfunction
endpackage

// File: rtl/trig_ctl_legalize.sv
module trig_ctl_legalize
   import dbg_trig_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] raw,
   output logic [XLEN-1:0] clean
);
   logic [3:0] code;

   generate
      if (XLEN == 64) begin : g_wide
         assign code = {raw[22:21], raw[17:16]};
      end else begin : g_narrow
         assign code = {2'b00, raw[17:16]};
      end
   endgenerate

   always_comb begin
      clean = '0;
      clean[XLEN-1 -: 4] = KIND_AM;
      clean[B_LD] = raw[B_LD];
      clean[B_ST] = raw[B_ST];
      clean[B_EX] = raw[B_EX];
      clean[B_U]  = raw[B_U];
      clean[B_S]  = raw[B_S];
      clean[B_M]  = raw[B_M];
      if (size_ok(code)) begin
         clean[17:16] = raw[17:16];
         if (XLEN == 64) clean[22:21] = raw[22:21];
      end
   end
endmodule

// File: rtl/trig_slot.sv
module trig_slot
   import dbg_trig_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_ctl,
   input  logic            wr_cmp,
   input  logic [XLEN-1:0] ctl_new,
   input  logic [XLEN-1:0] cmp_new,
   input  logic [1:0]      priv,
   input  logic            fetch_vld,
   input  logic [XLEN-1:0] fetch_pc,
   input  logic            mem_vld,
   input  logic            mem_store,
   input  logic [XLEN-1:0] mem_addr,
   input  logic [1:0]      mem_sz,
   output logic [XLEN-1:0] ctl_q,
   output logic [XLEN-1:0] cmp_q,
   output logic            fetch_hit,
   output logic            mem_hit
);
   localparam logic [XLEN-1:0] CTL_RST = {KIND_AM, {(XLEN-4){1'b0}}};

   logic [3:0]    code;
   logic          armed, mode_ok, dir_ok, overlap;
   logic [XLEN:0] win_end, acc_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_RST;
         cmp_q <= '0;
      end else begin
         if (wr_ctl) ctl_q <= ctl_new;
         if (wr_cmp) cmp_q <= cmp_new;
      end
   end

   generate
      if (XLEN == 64) begin : g_wide
         assign code = {ctl_q[22:21], ctl_q[17:16]};
      end else begin : g_narrow
         assign code = {2'b00, ctl_q[17:16]};
      end
   endgenerate

   always_comb begin
      armed = (ctl_q[B_U] | ctl_q[B_S] | ctl_q[B_M]) &
              (ctl_q[B_LD] | ctl_q[B_ST] | ctl_q[B_EX]);
      case (priv)
         PRV_U:   mode_ok = ctl_q[B_U];
         PRV_S:   mode_ok = ctl_q[B_S];
         PRV_M:   mode_ok = ctl_q[B_M];
         default: mode_ok = 1'b0;
      endcase
      dir_ok  = mem_store ? ctl_q[B_ST] : ctl_q[B_LD];
      win_end = {1'b0, cmp_q} + {{(XLEN-3){1'b0}}, size_bytes(code)};
      acc_end = {1'b0, mem_addr} + ({{XLEN{1'b0}}, 1'b1} << mem_sz);
      overlap = ({1'b0, mem_addr} < win_end) && ({1'b0, cmp_q} < acc_end);
      fetch_hit = armed & mode_ok & fetch_vld & ctl_q[B_EX] & (fetch_pc == cmp_q);
      mem_hit   = armed & mode_ok & mem_vld & dir_ok & overlap;
   end
endmodule

// File: rtl/trig_pick_lowest.sv
module trig_pick_lowest #(
   parameter int N   = 2,
   parameter int IDW = 1
) (
   input  logic [N-1:0]   req,
   output logic           any,
   output logic [IDW-1:0] idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDW'(i);
      end
   end
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
   import dbg_trig_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int NUM_TRIG = 2,
   parameter int IDX_W    = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csr_en,
   input  logic             csr_we,
   input  logic [11:0]      csr_addr,
   input  logic [XLEN-1:0]  csr_wdata,
   output logic [XLEN-1:0]  csr_rdata,
   output logic             csr_illegal,
   input  logic [1:0]       priv,
   input  logic             fetch_vld,
   input  logic [XLEN-1:0]  fetch_pc,
   input  logic             mem_vld,
   input  logic             mem_store,
   input  logic [XLEN-1:0]  mem_addr,
   input  logic [1:0]       mem_sz,
   output logic             brk_hit,
   output logic [IDX_W-1:0] brk_idx,
   output logic             wpt_hit,
   output logic [IDX_W-1:0] wpt_idx
);
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("dbg_trig_unit: XLEN must be 32 or 64");
      end
      if (NUM_TRIG < 1) begin : g_bad_num
         $error("dbg_trig_unit: NUM_TRIG must be at least 1");
      end
   endgenerate

   logic [XLEN-1:0]  tsel_q;
   logic [XLEN-1:0]  ctl_clean;
   logic [XLEN-1:0]  ctl_a [NUM_TRIG];
   logic [XLEN-1:0]  cmp_a [NUM_TRIG];
   logic [NUM_TRIG-1:0] f_req, m_req;
   logic             hit_sel, hit_ctl, hit_cmp, hit_aux, sel_ok;
   logic [IDX_W-1:0] sel_idx;

   assign hit_sel = csr_addr == ADR_SEL;
   assign hit_ctl = csr_addr == ADR_CTL;
   assign hit_cmp = csr_addr == ADR_CMP;
   assign hit_aux = csr_addr == ADR_AUX;
   assign sel_ok  = tsel_q < XLEN'(NUM_TRIG);
   assign sel_idx = tsel_q[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        tsel_q <= '0;
      else if (csr_en && csr_we && hit_sel) tsel_q <= csr_wdata;
   end

   trig_ctl_legalize #(.XLEN(XLEN)) u_legal (.raw(csr_wdata), .clean(ctl_clean));

   for (genvar i = 0; i < NUM_TRIG; i++) begin : g_slot
      logic wr_here;
      assign wr_here = csr_en && csr_we && sel_ok && (sel_idx == IDX_W'(i));
      trig_slot #(.XLEN(XLEN)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .wr_ctl(wr_here && hit_ctl), .wr_cmp(wr_here && hit_cmp),
         .ctl_new(ctl_clean), .cmp_new(csr_wdata),
         .priv(priv),
         .fetch_vld(fetch_vld), .fetch_pc(fetch_pc),
         .mem_vld(mem_vld), .mem_store(mem_store),
         .mem_addr(mem_addr), .mem_sz(mem_sz),
         .ctl_q(ctl_a[i]), .cmp_q(cmp_a[i]),
         .fetch_hit(f_req[i]), .mem_hit(m_req[i])
      );
   end

   always_comb begin
      csr_illegal = csr_en && (hit_aux || ((hit_ctl || hit_cmp) && !sel_ok));
      csr_rdata   = '0;
      if (hit_sel)                csr_rdata = tsel_q;
      else if (hit_ctl && sel_ok) csr_rdata = ctl_a[sel_idx];
      else if (hit_cmp && sel_ok) csr_rdata = cmp_a[sel_idx];
   end

   trig_pick_lowest #(.N(NUM_TRIG), .IDW(IDX_W)) u_pick_f (
      .req(f_req), .any(brk_hit), .idx(brk_idx));
   trig_pick_lowest #(.N(NUM_TRIG), .IDW(IDX_W)) u_pick_m (
      .req(m_req), .any(wpt_hit), .idx(wpt_idx));
endmodule

// File: rtl/dbg_trig_unit_chk.sv
module dbg_trig_unit_chk #(
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            csr_en,
   input logic            csr_we,
   input logic [11:0]     csr_addr,
   input logic [XLEN-1:0] csr_rdata,
   input logic            csr_illegal,
   input logic [1:0]      priv,
   input logic            fetch_vld,
   input logic            mem_vld,
   input logic            brk_hit,
   input logic            wpt_hit
);
   // R2
   sel_never_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_en && csr_addr == 12'h7A0) |-> !csr_illegal);
   // R3
   aux_always_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_en && csr_addr == 12'h7A3) |-> csr_illegal);
   // R4
   ctl_read_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_en && !csr_we && csr_addr == 12'h7A1 && !csr_illegal) |->
      (csr_rdata[XLEN-1 -: 4] == 4'd2 && !csr_rdata[XLEN-5] &&
       csr_rdata[15:7] == '0 && csr_rdata[20:18] == '0 && !csr_rdata[5]));
   // R7
   brk_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_hit |-> fetch_vld);
   // R8
   wpt_needs_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wpt_hit |-> mem_vld);
   // R9
   priv_two_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (priv == 2'd2) |-> (!brk_hit && !wpt_hit));
endmodule

bind dbg_trig_unit dbg_trig_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/sim_dbg_trig_unit.sv
module sim_dbg_trig_unit;
   localparam int XLEN = 64;
   localparam logic [63:0] T2 = 64'h2000_0000_0000_0000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        csr_en = 0, csr_we = 0;
   logic [11:0] csr_addr = '0;
   logic [63:0] csr_wdata = '0, csr_rdata;
   logic        csr_illegal;
   logic [1:0]  priv = 2'd3;
   logic        fetch_vld = 0, mem_vld = 0, mem_store = 0;
   logic [63:0] fetch_pc = '0, mem_addr = '0;
   logic [1:0]  mem_sz = '0;
   logic        brk_hit, wpt_hit;
   logic [0:0]  brk_idx, wpt_idx;

   int checks = 0, errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   dbg_trig_unit #(.XLEN(XLEN), .NUM_TRIG(2)) u0 (.*);

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      csr_en = 1; csr_we = 1; csr_addr = a; csr_wdata = d;
      @(negedge clk);
      csr_en = 0; csr_we = 0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [63:0] d, output logic ill);
      @(negedge clk);
      csr_en = 1; csr_we = 0; csr_addr = a;
      #5; d = csr_rdata; ill = csr_illegal;
      @(negedge clk);
      csr_en = 0;
   endtask

   task automatic rd_chk(input logic [11:0] a, input logic [63:0] exp, input logic exp_ill, input string req);
      logic [63:0] d; logic ill;
      rd(a, d, ill);
      chk(d == exp, req, d, exp);
      chk(ill == exp_ill, req, 64'(ill), 64'(exp_ill));
   endtask

   task automatic fetch_chk(input logic [63:0] pc, input logic [1:0] p, input bit exp_hit, input logic exp_idx, input string req);
      @(negedge clk);
      fetch_vld = 1; fetch_pc = pc; priv = p;
      #5;
      chk(brk_hit == exp_hit, req, 64'(brk_hit), 64'(exp_hit));
      if (exp_hit) chk(brk_idx == exp_idx, req, 64'(brk_idx), 64'(exp_idx));
      fetch_vld = 0; priv = 2'd3;
   endtask

   task automatic mem_chk(input logic [63:0] a, input logic [1:0] sz, input bit st, input bit exp_hit, input logic exp_idx, input string req);
      @(negedge clk);
      mem_vld = 1; mem_addr = a; mem_sz = sz; mem_store = st;
      #5;
      chk(wpt_hit == exp_hit, req, 64'(wpt_hit), 64'(exp_hit));
      if (exp_hit) chk(wpt_idx == exp_idx, req, 64'(wpt_idx), 64'(exp_idx));
      mem_vld = 0;
   endtask

   task automatic t_reset;
      rd_chk(12'h7A0, 64'h0, 0, "R1 select");
      rd_chk(12'h7A1, T2, 0, "R1 control");
      rd_chk(12'h7A2, 64'h0, 0, "R1 address");
      fetch_chk(64'h0, 2'd3, 0, 0, "R1 no fetch hit");
      mem_chk(64'h0, 2'd3, 0, 0, 0, "R1 no mem hit");
   endtask

   task automatic t_select;
      wr(12'h7A0, 64'hDEAD_BEEF_0000_0005);
      rd_chk(12'h7A0, 64'hDEAD_BEEF_0000_0005, 0, "R2 readback");
      rd_chk(12'h7A1, 64'h0, 1, "R2 ctl unavailable");
      wr(12'h7A2, 64'h1234);
      wr(12'h7A0, 64'h0);
      rd_chk(12'h7A2, 64'h0, 0, "R2 dropped write");
      rd_chk(12'h7A3, 64'h0, 1, "R3 aux illegal sel0");
      wr(12'h7A0, 64'h1);
      rd_chk(12'h7A3, 64'h0, 1, "R3 aux illegal sel1");
   endtask

   task automatic t_legal;
      wr(12'h7A0, 64'h0);
      wr(12'h7A1, '1);
      rd_chk(12'h7A1, T2 | 64'h5F, 0, "R4 all ones, R5 code 15");
      wr(12'h7A1, 64'h0000_0000_0020_0047);
      rd_chk(12'h7A1, T2 | 64'h47, 0, "R5 code 4 dropped");
      wr(12'h7A1, 64'h0000_0000_0021_0047);
      rd_chk(12'h7A1, T2 | 64'h0021_0047, 0, "R5 code 5 kept");
      wr(12'h7A1, 64'h0000_0000_0003_0041);
      rd_chk(12'h7A1, T2 | 64'h0003_0041, 0, "R5 code 3 kept");
      wr(12'h7A1, 64'h0);
   endtask

   task automatic t_enable;
      wr(12'h7A0, 64'h0);
      wr(12'h7A2, 64'h1000);
      wr(12'h7A1, 64'h4);
      fetch_chk(64'h1000, 2'd3, 0, 0, "R6 no mode bit");
      wr(12'h7A1, 64'h40);
      fetch_chk(64'h1000, 2'd3, 0, 0, "R6 no access bit");
      // write and fetch together: old word still governs (R11)
      @(negedge clk);
      csr_en = 1; csr_we = 1; csr_addr = 12'h7A1; csr_wdata = 64'h44;
      fetch_vld = 1; fetch_pc = 64'h1000; priv = 2'd3;
      #5; chk(brk_hit == 0, "R11 strobe cycle", 64'(brk_hit), 64'h0);
      @(negedge clk);
      csr_en = 0; csr_we = 0;
      #5; chk(brk_hit == 1, "R11 next cycle", 64'(brk_hit), 64'h1);
      fetch_vld = 0;
      fetch_chk(64'h1000, 2'd3, 1, 0, "R7 exact match");
      fetch_chk(64'h1001, 2'd3, 0, 0, "R7 off by one");
      fetch_chk(64'h1000, 2'd0, 0, 0, "R9 U not enabled");
      fetch_chk(64'h1000, 2'd2, 0, 0, "R9 priv code 2");
      wr(12'h7A1, 64'h0C);
      fetch_chk(64'h1000, 2'd0, 1, 0, "R9 U enabled");
      fetch_chk(64'h1000, 2'd3, 0, 0, "R9 M not enabled");
      mem_chk(64'h1000, 2'd0, 0, 0, 0, "R8 exec-only no mem");
      wr(12'h7A1, 64'h0);
   endtask

   task automatic t_watch;
      wr(12'h7A0, 64'h1);
      wr(12'h7A2, 64'h2004);
      wr(12'h7A1, 64'h0003_0041);   // 4-byte window, load, M
      mem_chk(64'h2000, 2'd2, 0, 0, 0, "R8 ends before window");
      mem_chk(64'h2002, 2'd2, 0, 1, 1, "R8 partial overlap");
      mem_chk(64'h2004, 2'd0, 1, 0, 0, "R8 store ignored");
      mem_chk(64'h2007, 2'd0, 0, 1, 1, "R8 last byte");
      mem_chk(64'h2008, 2'd0, 0, 0, 0, "R8 past window");
      wr(12'h7A1, 64'h0000_0000_0020_0042);   // code 4 -> any, store, M
      mem_chk(64'h200B, 2'd0, 1, 1, 1, "R5 R8 fallback 8B window");
      mem_chk(64'h200C, 2'd0, 1, 0, 0, "R8 beyond 8B window");
      mem_chk(64'h2004, 2'd3, 0, 0, 0, "R8 load ignored");
   endtask

   task automatic t_prio;
      wr(12'h7A0, 64'h0); wr(12'h7A2, 64'h3000); wr(12'h7A1, 64'h44);
      wr(12'h7A0, 64'h1); wr(12'h7A2, 64'h3000); wr(12'h7A1, 64'h44);
      fetch_chk(64'h3000, 2'd3, 1, 0, "R10 lowest wins");
      wr(12'h7A0, 64'h0); wr(12'h7A1, 64'h0);
      fetch_chk(64'h3000, 2'd3, 1, 1, "R10 only index 1");
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset;
      t_select;
      t_legal;
      t_enable;
      t_watch;
      t_prio;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule